// File: doc/BRIEF.md
# Two-Level Power-Management Interrupt Aggregator

This block gathers single-cycle event pulses from the many sources of a power-management device into five 16-bit pending words. It also detects edges on sixteen general-purpose pins. Each pending word has its own enable word, in which a set bit blocks a source. Pending bits that are not blocked are folded, group by group, into a 13-bit summary word. Each summary bit stands for one functional group of sources. A group-level block word then decides which summary bits may reach the single active-low, level-type interrupt line.

The host uses a synchronous register port to read the summary word and then the pending word behind it. It acknowledges an event by writing ones to the bits it has handled. Zero bits in the write leave their pending bits untouched, so an event that arrives while the host is working is kept. The interrupt line can drive actively in both directions (push-pull), or only pull low and otherwise release the pin (open-drain). The two touch events each have their own summary bit, so the host can service them from the summary word alone.

Top module: `irq_agg_top`

## Requirements
- R1: After reset every pending word reads 0x0000, every source block word (addresses 5..9) reads 0xFFFF, the group block word (address 11) reads 0x1FFF, the drive-mode word (address 12) reads 0x0001 (open-drain), and the interrupt line is inactive.
- R2: A source pulse sets its pending bit at the next clock edge, even while that source is blocked. While the bit is blocked it does not set a summary bit and does not assert the line. Source pulse input bit r*16+b feeds pending word r (address r), bit b, for r = 0..3.
- R3: A write to a pending word (addresses 0..4) clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: When a source pulse and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R5: Summary word (address 10, read-only) bit g is 1 while any unblocked pending bit of group g is set. The groups are: 0 temperature (word 0 bit 0), 1 pins (word 4 bits 0..15), 2 on-button (word 0 bit 1), 3 power path (word 0 bits 2..4), 4 watchdog (word 0 bit 5), 5 clock/alarm (word 0 bits 6..7), 6 charger (word 1 bits 0..7), 9 converter monitor (word 0 bits 8..12), 10 current sinks (word 1 bits 8..9), 11 regulator over-current (word 3 bits 4..5).
- R6: Group 12 (under-voltage) spans two words: linear regulators in word 2 bits 0..9, switching converters in word 3 bits 0..3.
- R7: Touch pen-down (word 0 bit 13) and touch data (word 0 bit 14) have their own summary bits, 8 and 7.
- R8: The interrupt is active exactly when some summary bit g is 1 and bit g of the group block word is 0. Writing 0 to the group block word lets every group through. The summary word itself ignores the group block word.
- R9: Pin n reports into word 4 bit n. The both-edges word (address 13) bit n set detects both edges. Otherwise the polarity word (address 14) bit n selects rising (1) or falling (0). Both words reset to 0.
- R10: In open-drain mode (address 12 bit 0 = 1) the line drive is 0, and the output enable is 1 only while the interrupt is active. In push-pull mode (bit 0 = 0) the output enable is always 1 and the drive is the inverse of the interrupt.
- R11: The line returns to inactive in the cycle after the write that clears or blocks the last unblocked pending bit.
- R12: A read request returns its data on the read-data port after the next clock edge. Unmapped addresses (15) read 0, and unimplemented pending bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_evt_i | input | 64 | Event pulses, bit r*16+b to pending word r bit b |
| gpio_i | input | 16 | General-purpose pin levels for edge detection |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| irq_drv_o | output | 1 | Interrupt line drive value (active low) |
| irq_oe_o | output | 1 | Interrupt line output enable |

## Verification
A pending bit that is wrong inside the block shows up at the ports within one cycle. It changes the line level right away, and it shows in the summary word on the next read. A lost event shows as a line that never asserts. A bit that does not clear shows as a line that stays low after the acknowledging write. The bench walks each source bit through its group so that a wrong mapping reads back as a wrong summary bit. It also hits the same-cycle set/clear race and every pin edge mode, where a wrong priority or a wrong polarity changes the pending word seen on the next read.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int REG_W    = 16;
    localparam int NUM_REGS = 5;
    localparam int NUM_GPIO = 16;
    localparam int ADDR_W   = 4;
    localparam int NUM_GRP  = 13;

    localparam int SRC_W      = (NUM_REGS - 1) * REG_W;
    localparam int ADR_STAT0  = 0;
    localparam int ADR_MASK0  = NUM_REGS;
    localparam int ADR_PRIM   = 2 * NUM_REGS;
    localparam int ADR_PMASK  = ADR_PRIM + 1;
    localparam int ADR_CFG    = ADR_PRIM + 2;
    localparam int ADR_GBOTH  = ADR_PRIM + 3;
    localparam int ADR_GPOL   = ADR_PRIM + 4;

    typedef enum logic [3:0] {
        GRP_TEMP  = 4'd0,
        GRP_GPIO  = 4'd1,
        GRP_ON    = 4'd2,
        GRP_PWR   = 4'd3,
        GRP_WDOG  = 4'd4,
        GRP_RTC   = 4'd5,
        GRP_CHG   = 4'd6,
        GRP_TDATA = 4'd7,
        GRP_TPEN  = 4'd8,
        GRP_ADC   = 4'd9,
        GRP_SINK  = 4'd10,
        GRP_HICUR = 4'd11,
        GRP_UV    = 4'd12,
        GRP_NONE  = 4'd15
    } grp_e;

    typedef enum logic {
        DRV_PUSHPULL  = 1'b0,
        DRV_OPENDRAIN = 1'b1
    } drv_mode_e;

    typedef struct packed {
        logic both;
        logic pol;
    } edge_cfg_t;

    // Source layout: which summary group owns pending word r, bit b.
    function automatic grp_e grp_of(input int r, input int b);
        grp_e g;
        g = GRP_NONE;
        case (r)
            0: begin
                if (b == 0)       g = GRP_TEMP;
                else if (b == 1)  g = GRP_ON;
                else if (b <= 4)  g = GRP_PWR;
                else if (b == 5)  g = GRP_WDOG;
                else if (b <= 7)  g = GRP_RTC;
                else if (b <= 12) g = GRP_ADC;
                else if (b == 13) g = GRP_TPEN;
                else if (b == 14) g = GRP_TDATA;
            end
            1: begin
                if (b <= 7)      g = GRP_CHG;
                else if (b <= 9) g = GRP_SINK;
            end
            2: begin
                if (b <= 9) g = GRP_UV;
            end
            3: begin
                if (b <= 3)      g = GRP_UV;
                else if (b <= 5) g = GRP_HICUR;
            end
            4: begin
                if (b < NUM_GPIO) g = GRP_GPIO;
            end
            default: g = GRP_NONE;
        endcase
        return g;
    endfunction

    function automatic logic [REG_W-1:0] impl_bits(input int r);
        logic [REG_W-1:0] v;
        v = '0;
        for (int b = 0; b < REG_W; b++) begin
            v[b] = (grp_of(r, b) != GRP_NONE);
        end
        return v;
    endfunction

endpackage

// File: rtl/irq_gpio_edge.sv
module irq_gpio_edge
    import irq_agg_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      pin_i,
    input  edge_cfg_t cfg_i,
    output logic      evt_o
);

    logic prev_q;
    logic rise;
    logic fall;

    // The previous level tracks the pin during reset as well, so a pin
    // that is already high does not look like an edge once reset ends.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q <= pin_i;
        end else begin
            prev_q <= pin_i;
        end
    end

    assign rise = pin_i & ~prev_q;
    assign fall = ~pin_i & prev_q;

    always_comb begin
        if (cfg_i.both) begin
            evt_o = rise | fall;
        end else if (cfg_i.pol) begin
            evt_o = rise;
        end else begin
            evt_o = fall;
        end
    end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   IMPL = '1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] set_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_data_i,
    output logic [W-1:0] stat_o
);

    logic [W-1:0] stat_q;
    logic [W-1:0] clr_v;

    assign clr_v = clr_we_i ? clr_data_i : '0;

    // A new event on the same edge as an acknowledge survives it.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stat_q <= '0;
        end else begin
            stat_q <= ((stat_q & ~clr_v) | set_i) & IMPL;
        end
    end

    assign stat_o = stat_q;

    AST_EVT_LATCHED: assert property (@(posedge clk_i) disable iff (rst_i)
        (|(set_i & IMPL)) |=> ((stat_o & $past(set_i & IMPL)) == $past(set_i & IMPL))); // R4

    AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_we_i |=> ((stat_o & $past(clr_data_i) & ~$past(set_i)) == '0)); // R3

    AST_W1C_KEEPS_ZEROS: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_we_i |=> (((stat_o ^ $past(stat_o)) & ~$past(clr_data_i) & ~$past(set_i)) == '0)); // R3

endmodule

// File: rtl/irq_summary.sv
module irq_summary
    import irq_agg_pkg::*;
#(
    parameter int NR = 5,
    parameter int W  = 16,
    parameter int NG = 13
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NR*W-1:0] stat_flat_i,
    input  logic [NR*W-1:0] mask_flat_i,
    input  logic [NG-1:0]   pmask_i,
    input  drv_mode_e       mode_i,
    output logic [NG-1:0]   primary_o,
    output logic            drv_o,
    output logic            oe_o
);

    logic [NR*W-1:0] pend;
    logic            active;

    assign pend = stat_flat_i & ~mask_flat_i;

    always_comb begin
        primary_o = '0;
        for (int g = 0; g < NG; g++) begin
            for (int r = 0; r < NR; r++) begin
                for (int b = 0; b < W; b++) begin
                    if ((int'(grp_of(r, b)) == g) && pend[r*W + b]) begin
                        primary_o[g] = 1'b1;
                    end
                end
            end
        end
    end

    assign active = |(primary_o & ~pmask_i);

    always_comb begin
        if (mode_i == DRV_OPENDRAIN) begin
            oe_o  = active;
            drv_o = 1'b0;
        end else begin
            oe_o  = 1'b1;
            drv_o = ~active;
        end
    end

    AST_QUIET_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (rst_i)
        (stat_flat_i == '0) |-> !active); // R11

    AST_BLOCKED_NO_SUMMARY: assert property (@(posedge clk_i) disable iff (rst_i)
        (mask_flat_i == '1) |-> (primary_o == '0)); // R2

    AST_OD_NEVER_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == DRV_OPENDRAIN && oe_o) |-> !drv_o); // R10

    AST_PP_ALWAYS_DRIVEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == DRV_PUSHPULL) |-> oe_o); // R10

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int W     = REG_W,
    parameter int NR    = NUM_REGS,
    parameter int NGPIO = NUM_GPIO,
    parameter int AW    = ADDR_W,
    parameter int NG    = NUM_GRP,
    localparam int SW   = (NR - 1) * W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [SW-1:0] src_evt_i,
    input  logic [NGPIO-1:0] gpio_i,
    input  logic          bus_we_i,
    input  logic          bus_re_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [W-1:0]  bus_wdata_i,
    output logic [W-1:0]  bus_rdata_o,
    output logic          irq_drv_o,
    output logic          irq_oe_o
);

    logic [W-1:0]     stat_arr [NR];
    logic [W-1:0]     mask_q   [NR];
    logic [NR*W-1:0]  stat_flat;
    logic [NR*W-1:0]  mask_flat;
    logic [NG-1:0]    pmask_q;
    drv_mode_e        mode_q;
    logic [NGPIO-1:0] gpio_both_q;
    logic [NGPIO-1:0] gpio_pol_q;
    logic [NGPIO-1:0] gpio_evt;
    logic [NG-1:0]    primary;
    logic [W-1:0]     rdata_q;
    int               addr_i;

    assign addr_i = int'(bus_addr_i);

    // Pin edge detectors
    for (genvar n = 0; n < NGPIO; n++) begin : g_pin
        edge_cfg_t cfg_n;
        assign cfg_n.both = gpio_both_q[n];
        assign cfg_n.pol  = gpio_pol_q[n];
        irq_gpio_edge u_edge (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .pin_i (gpio_i[n]),
            .cfg_i (cfg_n),
            .evt_o (gpio_evt[n])
        );
    end

    // Pending words; the last one is fed by the pin detectors
    for (genvar r = 0; r < NR; r++) begin : g_bank
        logic [W-1:0] set_v;
        logic         clr_we;
        if (r < NR - 1) begin : g_src
            assign set_v = src_evt_i[r*W +: W];
        end else begin : g_pin_word
            assign set_v = W'(gpio_evt);
        end
        assign clr_we = bus_we_i && (addr_i == ADR_STAT0 + r);
        irq_status_bank #(
            .W    (W),
            .IMPL (impl_bits(r))
        ) u_bank (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .set_i      (set_v),
            .clr_we_i   (clr_we),
            .clr_data_i (bus_wdata_i),
            .stat_o     (stat_arr[r])
        );
        assign stat_flat[r*W +: W] = stat_arr[r];
        assign mask_flat[r*W +: W] = mask_q[r];
    end

    // Configuration registers
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int r = 0; r < NR; r++) begin
                mask_q[r] <= '1;
            end
            pmask_q     <= '1;
            mode_q      <= DRV_OPENDRAIN;
            gpio_both_q <= '0;
            gpio_pol_q  <= '0;
        end else if (bus_we_i) begin
            for (int r = 0; r < NR; r++) begin
                if (addr_i == ADR_MASK0 + r) begin
                    mask_q[r] <= bus_wdata_i;
                end
            end
            if (addr_i == ADR_PMASK) pmask_q     <= bus_wdata_i[NG-1:0];
            if (addr_i == ADR_CFG)   mode_q      <= drv_mode_e'(bus_wdata_i[0]);
            if (addr_i == ADR_GBOTH) gpio_both_q <= bus_wdata_i[NGPIO-1:0];
            if (addr_i == ADR_GPOL)  gpio_pol_q  <= bus_wdata_i[NGPIO-1:0];
        end
    end

    // Registered read port
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rdata_q <= '0;
        end else if (bus_re_i) begin
            rdata_q <= '0;
            for (int r = 0; r < NR; r++) begin
                if (addr_i == ADR_STAT0 + r) rdata_q <= stat_arr[r];
                if (addr_i == ADR_MASK0 + r) rdata_q <= mask_q[r];
            end
            if (addr_i == ADR_PRIM)  rdata_q <= W'(primary);
            if (addr_i == ADR_PMASK) rdata_q <= W'(pmask_q);
            if (addr_i == ADR_CFG)   rdata_q <= W'(mode_q);
            if (addr_i == ADR_GBOTH) rdata_q <= W'(gpio_both_q);
            if (addr_i == ADR_GPOL)  rdata_q <= W'(gpio_pol_q);
        end
    end

    assign bus_rdata_o = rdata_q;

    irq_summary #(
        .NR (NR),
        .W  (W),
        .NG (NG)
    ) u_sum (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .stat_flat_i (stat_flat),
        .mask_flat_i (mask_flat),
        .pmask_i     (pmask_q),
        .mode_i      (mode_q),
        .primary_o   (primary),
        .drv_o       (irq_drv_o),
        .oe_o        (irq_oe_o)
    );

    AST_MASKS_AFTER_RESET: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (mask_flat == '1 && pmask_q == '1)); // R1

    for (genvar n = 0; n < NGPIO; n++) begin : g_pin_chk
        AST_PIN_RISE_SEEN: assert property (@(posedge clk_i) disable iff (rst_i)
            (!gpio_both_q[n] && gpio_pol_q[n] && $rose(gpio_i[n])) |=> stat_arr[NR-1][n]); // R9
        AST_PIN_ANY_EDGE: assert property (@(posedge clk_i) disable iff (rst_i)
            (gpio_both_q[n] && $fell(gpio_i[n])) |=> stat_arr[NR-1][n]); // R9
    end

endmodule

// File: tb/irq_agg_top_tb_top.sv
module irq_agg_top_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [2:0]  r;
        logic [3:0]  b;
        logic [15:0] prim;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 4'd0,  16'h0001},
        '{3'd0, 4'd1,  16'h0004},
        '{3'd0, 4'd3,  16'h0008},
        '{3'd0, 4'd5,  16'h0010},
        '{3'd0, 4'd7,  16'h0020},
        '{3'd0, 4'd9,  16'h0200},
        '{3'd0, 4'd13, 16'h0100},
        '{3'd0, 4'd14, 16'h0080},
        '{3'd1, 4'd2,  16'h0040},
        '{3'd1, 4'd9,  16'h0400},
        '{3'd2, 4'd4,  16'h1000},
        '{3'd3, 4'd2,  16'h1000},
        '{3'd3, 4'd5,  16'h0800}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] src_evt;
    logic [15:0] gpio;
    logic        we, re;
    logic [3:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        irq_drv, irq_oe;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;
    logic [15:0] v;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_agg_top dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .src_evt_i   (src_evt),
        .gpio_i      (gpio),
        .bus_we_i    (we),
        .bus_re_i    (re),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_drv_o   (irq_drv),
        .irq_oe_o    (irq_oe)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; addr = 4'(a); wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        @(negedge clk);
        re = 1'b1; addr = 4'(a);
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input int r, input int b);
        @(negedge clk);
        src_evt[r*16 + b] = 1'b1;
        @(negedge clk);
        src_evt = '0;
    endtask

    function automatic logic [15:0] line();
        return {14'b0, irq_oe, irq_drv};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; src_evt = '0; gpio = '0; we = 0; re = 0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int r = 0; r < 5; r++) begin
            rd(r, v);     chk("R1 pending word reset", v, 16'h0000);
            rd(5 + r, v); chk("R1 block word reset", v, 16'hFFFF);
        end
        rd(11, v); chk("R1 group block reset", v, 16'h1FFF);
        rd(12, v); chk("R1 drive mode reset", v, 16'h0001);
        chk("R1 line inactive", line(), 16'h0000);

        // R2: latched while blocked, no summary, no line
        pulse(0, 0);
        rd(0, v);  chk("R2 blocked event latched", v, 16'h0001);
        rd(10, v); chk("R2 blocked no summary", v, 16'h0000);
        chk("R2 blocked line idle", line(), 16'h0000);
        wr(0, 16'h0001);

        // R8: open all groups, unblock all sources
        for (int r = 0; r < 5; r++) wr(5 + r, 16'h0000);
        wr(11, 16'h0000);

        // R5 R6 R7 R11: table walk over source layout
        for (int i = 0; i < NV; i++) begin
            pulse(int'(VECS[i].r), int'(VECS[i].b));
            rd(int'(VECS[i].r), v);
            chk("R5 pending bit", v, 16'h0001 << VECS[i].b);
            rd(10, v);
            chk("R5 R6 R7 summary group", v, VECS[i].prim);
            chk("R10 open-drain active", line(), 16'h0002);
            wr(int'(VECS[i].r), 16'h0001 << VECS[i].b);
            chk("R11 line released after clear", line(), 16'h0000);
            rd(int'(VECS[i].r), v);
            chk("R3 cleared", v, 16'h0000);
        end

        // R3: only written ones clear
        @(negedge clk);
        src_evt[16] = 1'b1; src_evt[17] = 1'b1;
        @(negedge clk);
        src_evt = '0;
        wr(1, 16'h0001);
        rd(1, v); chk("R3 zero bit kept", v, 16'h0002);
        wr(1, 16'h0002);

        // R4: same-cycle set and clear, set wins
        @(negedge clk);
        src_evt[19] = 1'b1; we = 1'b1; addr = 4'd1; wdata = 16'h0008;
        @(negedge clk);
        src_evt = '0; we = 1'b0;
        rd(1, v); chk("R4 set beats clear", v, 16'h0008);
        wr(1, 16'h0008);
        rd(1, v); chk("R4 later clear works", v, 16'h0000);

        // R8: group block gates the line, not the summary
        pulse(0, 0);
        wr(11, 16'h0001);
        chk("R8 group blocked line idle", line(), 16'h0000);
        rd(10, v); chk("R8 summary ignores group block", v, 16'h0001);
        wr(11, 16'h0000);
        chk("R8 group open line active", line(), 16'h0002);
        // R11: blocking the source releases the line next cycle
        wr(5, 16'h0001);
        chk("R11 line released after block", line(), 16'h0000);
        wr(5, 16'h0000);
        wr(0, 16'h0001);

        // R10: push-pull drive
        wr(12, 16'h0000);
        chk("R10 push-pull idle high", line(), 16'h0003);
        pulse(1, 0);
        chk("R10 push-pull active low", line(), 16'h0002);
        wr(1, 16'h0001);
        chk("R10 push-pull released", line(), 16'h0003);
        wr(12, 16'h0001);

        // R9: pin edge modes
        @(negedge clk); gpio[0] = 1'b1;
        rd(4, v); chk("R9 falling mode ignores rise", v, 16'h0000);
        @(negedge clk); gpio[0] = 1'b0;
        rd(4, v); chk("R9 falling mode sees fall", v, 16'h0001);
        rd(10, v); chk("R9 pin summary group", v, 16'h0002);
        wr(4, 16'h0001);
        wr(14, 16'h0002);
        @(negedge clk); gpio[1] = 1'b1;
        rd(4, v); chk("R9 rising mode sees rise", v, 16'h0002);
        wr(4, 16'h0002);
        @(negedge clk); gpio[1] = 1'b0;
        rd(4, v); chk("R9 rising mode ignores fall", v, 16'h0000);
        wr(13, 16'h0004);
        @(negedge clk); gpio[2] = 1'b1;
        rd(4, v); chk("R9 both mode rise", v, 16'h0004);
        wr(4, 16'h0004);
        @(negedge clk); gpio[2] = 1'b0;
        rd(4, v); chk("R9 both mode fall", v, 16'h0004);
        wr(4, 16'h0004);

        // R12: unmapped address and unimplemented bits
        rd(15, v); chk("R12 unmapped reads zero", v, 16'h0000);
        @(negedge clk); src_evt[63:48] = 16'hFFFF;
        @(negedge clk); src_evt = '0;
        rd(3, v); chk("R12 unimplemented bits zero", v, 16'h003F);
        wr(3, 16'hFFFF);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule